// File: doc/BRIEF.md
# Debug Hardware Trigger Unit

This block sits beside a processor core and watches two streams of bus activity: instruction fetches and data-bus reads and writes. Each of its trigger slots holds a lower address, a data value and a control word. When the condition programmed into a slot matches, the slot fires. A fired slot raises the debug actions it selects: a halt request to the debug handler, a one-cycle pulse on an external trigger line, setting or clearing a sticky trace enable, a single trace sample strobe, or arming other slots.

Slots come in pairs. The even slot of a pair can treat its odd neighbour's address and data registers as inclusive upper bounds, which turns an exact comparison into a window comparison. A slot can also be marked as needing arming. Such a slot stays silent until some fired slot names it in its arm mask. This gives two-stage sequences such as "break on a write to X, but only after code at Y has run". A hardware breakpoint is simply an enabled instruction slot that compares the fetch address.

Configuration goes through a single-cycle write port: pick a slot, pick the field, and present the value. Every action output is registered. It appears in the cycle after the bus cycle that caused it.

Top module: `dbg_trigger_unit`

## Requirements
- R1: Reset zeroes every slot's control word (all slots disabled), clears armed state and trace enable, and holds trig_fired, dbg_break, ext_trig and trace_sample low.
- R2: A write with cfg_we high loads cfg_wdata into the slot named by cfg_trig. cfg_field selects the target: 0 for address, 1 for data, 2 for control; the value 3 changes no register. The control word bits are: 0 enable, 1 data bus (0 means instruction bus), 2 compare address, 3 compare data, 4 match reads, 5 match writes, 6 pair range, 7 needs arming, 8 break, 9 external pulse, 10 trace on, 11 trace off, 12 trace sample, 31:16 arm mask (bit n arms slot n).
- R3: An enabled instruction slot with address compare fires when ibus_valid is high and ibus_addr equals its address. trig_fired bit n and the slot's actions appear one cycle later.
- R4: A data slot ANDs its selected conditions on one dbus_valid cycle: address equal, data equal, and cycle type. Bits 4 and 5 accept a read (dbus_write 0) or a write (dbus_write 1); with both clear, either type matches.
- R5: With bit 6 set on even slot 2k, its compares become inclusive windows: [addr(2k), addr(2k+1)] and [data(2k), data(2k+1)]. Odd slot 2k+1 then never fires on its own.
- R6: A slot with bit 7 set fires only once armed. Arming takes effect in the cycle after the arming slot fires and then stays in place.
- R7: Any configuration write clears the armed state of every slot, and this clear wins over an arm in the same cycle.
- R8: When any fired slot selects break, dbg_break pulses and every other action of that cycle is suppressed: no external pulse, no sample, no arming, and no change to trace enable.
- R9: ext_trig is high for exactly the cycles after cycles in which a slot selecting it fired.
- R10: trace_en is set by trace on and cleared by trace off. It keeps its value otherwise, and trace off wins when both fire in one cycle.
- R11: trace_sample pulses only for data-bus slots; the sample bit of an instruction slot has no effect.
- R12: A slot whose enable bit is clear never fires, whatever the bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_trig | input | IDX_W | Slot index of the write |
| cfg_field | input | 2 | Field select: 0 address, 1 data, 2 control |
| cfg_wdata | input | CFG_W | Write value |
| ibus_valid | input | 1 | Instruction fetch present |
| ibus_addr | input | ADDR_W | Fetch address |
| dbus_valid | input | 1 | Data-bus transfer present |
| dbus_write | input | 1 | 1 for write, 0 for read |
| dbus_addr | input | ADDR_W | Data-bus address |
| dbus_data | input | DATA_W | Data-bus value |
| trig_fired | output | NUM_TRIG | Slots that fired in the previous cycle |
| dbg_break | output | 1 | Halt request pulse |
| ext_trig | output | 1 | External trigger pulse |
| trace_en | output | 1 | Sticky trace enable |
| trace_sample | output | 1 | Single trace sample strobe |

## Verification
The properties assume that reset is asserted from the first clock edge. They also assume the bus valid inputs are low while reset is held, so that a past-value check just after reset sees idle buses. The stimulus drives every input from the falling edge and keeps both buses idle during reset and around each configuration write. Slot programming is always finished before the bus cycles that test it. The properties also rely on the fact that data presented on a bus only counts when its valid is high; the bench changes address and data freely on idle cycles to exercise that.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

   localparam int MAX_TRIG = 16;

   // Control word of one trigger slot, bit 0 at the bottom.
   typedef struct packed {
      logic [MAX_TRIG-1:0] arm_mask;
      logic [2:0]          spare;
      logic                act_sample;
      logic                act_troff;
      logic                act_tron;
      logic                act_ext;
      logic                act_brk;
      logic                need_arm;
      logic                range_pair;
      logic                use_wr;
      logic                use_rd;
      logic                use_data;
      logic                use_addr;
      logic                on_dbus;
      logic                enable;
   } trig_ctrl_t;

   localparam int CTRL_W = $bits(trig_ctrl_t);

   typedef enum logic [1:0] {
      FLD_ADDR = 2'd0,
      FLD_DATA = 2'd1,
      FLD_CTRL = 2'd2,
      FLD_NONE = 2'd3
   } cfg_field_e;

endpackage

// File: rtl/dbgtrig_cfg_regs.sv
module dbgtrig_cfg_regs
   import dbgtrig_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int CFG_W    = 32,
   localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_trig,
   input  logic [1:0]        cfg_field,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [ADDR_W-1:0] addr_q [NUM_TRIG],
   output logic [DATA_W-1:0] data_q [NUM_TRIG],
   output trig_ctrl_t        ctrl_q [NUM_TRIG]
);

   cfg_field_e fld;
   assign fld = cfg_field_e'(cfg_field);

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
      logic sel;
      assign sel = cfg_we && (cfg_trig == IDX_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q[t] <= '0;
            data_q[t] <= '0;
            ctrl_q[t] <= '0;
         end else if (sel) begin
            case (fld)
               FLD_ADDR: addr_q[t] <= cfg_wdata[ADDR_W-1:0];
               FLD_DATA: data_q[t] <= cfg_wdata[DATA_W-1:0];
               FLD_CTRL: ctrl_q[t] <= trig_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
               default:  ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dbgtrig_match.sv
module dbgtrig_match #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              en,
   input  logic              on_dbus,
   input  logic              use_addr,
   input  logic              use_data,
   input  logic              use_rd,
   input  logic              use_wr,
   input  logic              suppress,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic [DATA_W-1:0] lo_data,
   input  logic [DATA_W-1:0] hi_data,
   input  logic              ibus_valid,
   input  logic [ADDR_W-1:0] ibus_addr,
   input  logic              dbus_valid,
   input  logic              dbus_write,
   input  logic [ADDR_W-1:0] dbus_addr,
   input  logic [DATA_W-1:0] dbus_data,
   output logic              hit
);

   logic [ADDR_W-1:0] cur_addr;
   logic              addr_ok;
   logic              data_ok;
   logic              type_ok;
   logic              bus_live;

   // An exact compare is a window whose bounds coincide.
   assign cur_addr = on_dbus ? dbus_addr : ibus_addr;
   assign addr_ok  = !use_addr || ((cur_addr >= lo_addr) && (cur_addr <= hi_addr));
   assign data_ok  = !on_dbus || !use_data ||
                     ((dbus_data >= lo_data) && (dbus_data <= hi_data));
   assign type_ok  = !on_dbus || !(use_rd || use_wr) ||
                     (use_rd && !dbus_write) || (use_wr && dbus_write);
   assign bus_live = on_dbus ? dbus_valid : ibus_valid;

   assign hit = en && !suppress && bus_live && addr_ok && data_ok && type_ok;

endmodule

// File: rtl/dbgtrig_action.sv
module dbgtrig_action
   import dbgtrig_pkg::*;
#(
   parameter int NUM_TRIG = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [NUM_TRIG-1:0] hit,
   input  trig_ctrl_t          ctrl [NUM_TRIG],
   output logic [NUM_TRIG-1:0] fired_q,
   output logic                brk_q,
   output logic                ext_q,
   output logic                trace_q,
   output logic                sample_q
);

   logic [NUM_TRIG-1:0] armed_q;
   logic [NUM_TRIG-1:0] fire;
   logic [NUM_TRIG-1:0] want_brk, want_ext, want_on, want_off, want_smp;
   logic [NUM_TRIG-1:0] arm_set;

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_qual
      assign fire[t]     = hit[t] && (!ctrl[t].need_arm || armed_q[t]);
      assign want_brk[t] = fire[t] && ctrl[t].act_brk;
      assign want_ext[t] = fire[t] && ctrl[t].act_ext;
      assign want_on[t]  = fire[t] && ctrl[t].act_tron;
      assign want_off[t] = fire[t] && ctrl[t].act_troff;
      assign want_smp[t] = fire[t] && ctrl[t].act_sample && ctrl[t].on_dbus;
   end

   always_comb begin
      arm_set = '0;
      for (int t = 0; t < NUM_TRIG; t++) begin
         if (fire[t]) arm_set |= ctrl[t].arm_mask[NUM_TRIG-1:0];
      end
   end

   logic any_brk;
   logic trace_d;
   logic [NUM_TRIG-1:0] armed_d;

   assign any_brk = |want_brk;

   always_comb begin
      trace_d = trace_q;
      if (!any_brk) begin
         if (|want_off)      trace_d = 1'b0;
         else if (|want_on)  trace_d = 1'b1;
      end
   end

   always_comb begin
      if (cfg_we)       armed_d = '0;
      else if (any_brk) armed_d = armed_q;
      else              armed_d = armed_q | arm_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q  <= '0;
         fired_q  <= '0;
         brk_q    <= 1'b0;
         ext_q    <= 1'b0;
         trace_q  <= 1'b0;
         sample_q <= 1'b0;
      end else begin
         armed_q  <= armed_d;
         fired_q  <= fire;
         brk_q    <= any_brk;
         ext_q    <= !any_brk && (|want_ext);
         trace_q  <= trace_d;
         sample_q <= !any_brk && (|want_smp);
      end
   end

endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
   import dbgtrig_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
   localparam int WIDE_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
   localparam int CFG_W   = (WIDE_W > CTRL_W) ? WIDE_W : CTRL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_trig,
   input  logic [1:0]          cfg_field,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic                ibus_valid,
   input  logic [ADDR_W-1:0]   ibus_addr,
   input  logic                dbus_valid,
   input  logic                dbus_write,
   input  logic [ADDR_W-1:0]   dbus_addr,
   input  logic [DATA_W-1:0]   dbus_data,
   output logic [NUM_TRIG-1:0] trig_fired,
   output logic                dbg_break,
   output logic                ext_trig,
   output logic                trace_en,
   output logic                trace_sample
);

   if (NUM_TRIG < 2 || (NUM_TRIG % 2) != 0 || NUM_TRIG > MAX_TRIG) begin : g_bad_count
      $error("NUM_TRIG must be even and between 2 and MAX_TRIG");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be positive");
   end

   logic [ADDR_W-1:0] addr_q [NUM_TRIG];
   logic [DATA_W-1:0] data_q [NUM_TRIG];
   trig_ctrl_t        ctrl_q [NUM_TRIG];
   logic [NUM_TRIG-1:0] hit;

   dbgtrig_cfg_regs #(
      .NUM_TRIG (NUM_TRIG),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CFG_W    (CFG_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_trig  (cfg_trig),
      .cfg_field (cfg_field),
      .cfg_wdata (cfg_wdata),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .ctrl_q    (ctrl_q)
   );

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
      logic [ADDR_W-1:0] hi_a;
      logic [DATA_W-1:0] hi_d;
      logic              supp;

      if ((t % 2) == 0) begin : g_lead
         // Leading slot: may borrow the neighbour's registers as upper bounds.
         assign hi_a = ctrl_q[t].range_pair ? addr_q[t+1] : addr_q[t];
         assign hi_d = ctrl_q[t].range_pair ? data_q[t+1] : data_q[t];
         assign supp = 1'b0;
      end else begin : g_follow
         assign hi_a = addr_q[t];
         assign hi_d = data_q[t];
         assign supp = ctrl_q[t-1].range_pair;
      end

      dbgtrig_match #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) u_match (
         .en         (ctrl_q[t].enable),
         .on_dbus    (ctrl_q[t].on_dbus),
         .use_addr   (ctrl_q[t].use_addr),
         .use_data   (ctrl_q[t].use_data),
         .use_rd     (ctrl_q[t].use_rd),
         .use_wr     (ctrl_q[t].use_wr),
         .suppress   (supp),
         .lo_addr    (addr_q[t]),
         .hi_addr    (hi_a),
         .lo_data    (data_q[t]),
         .hi_data    (hi_d),
         .ibus_valid (ibus_valid),
         .ibus_addr  (ibus_addr),
         .dbus_valid (dbus_valid),
         .dbus_write (dbus_write),
         .dbus_addr  (dbus_addr),
         .dbus_data  (dbus_data),
         .hit        (hit[t])
      );
   end

   dbgtrig_action #(
      .NUM_TRIG (NUM_TRIG)
   ) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .hit      (hit),
      .ctrl     (ctrl_q),
      .fired_q  (trig_fired),
      .brk_q    (dbg_break),
      .ext_q    (ext_trig),
      .trace_q  (trace_en),
      .sample_q (trace_sample)
   );

endmodule

// File: rtl/dbgtrig_chk.sv
module dbgtrig_chk #(
   parameter int NUM_TRIG = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ibus_valid,
   input logic                dbus_valid,
   input logic [NUM_TRIG-1:0] trig_fired,
   input logic                dbg_break,
   input logic                ext_trig,
   input logic                trace_en,
   input logic                trace_sample
);

   // R1: one edge of reset leaves every output quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (trig_fired == '0 && !dbg_break && !ext_trig && !trace_en && !trace_sample));

   // R8: break excludes the other pulses
   a_r8_break_alone: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_break |-> (!ext_trig && !trace_sample));

   // R8: break leaves trace enable untouched
   a_r8_break_keeps_trace: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_break |-> $stable(trace_en));

   // R3: a firing needs bus activity in the cycle before
   a_r3_fire_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (|trig_fired) |-> $past(ibus_valid || dbus_valid));

   // R11: a sample needs a data-bus cycle
   a_r11_sample_from_dbus: assert property (@(posedge clk) disable iff (!rst_n)
      trace_sample |-> $past(dbus_valid));

   // R9: the external pulse always comes with a firing slot
   a_r9_ext_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      ext_trig |-> (|trig_fired));

endmodule

bind dbg_trigger_unit dbgtrig_chk #(
   .NUM_TRIG (NUM_TRIG)
) u_dbgtrig_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ibus_valid   (ibus_valid),
   .dbus_valid   (dbus_valid),
   .trig_fired   (trig_fired),
   .dbg_break    (dbg_break),
   .ext_trig     (ext_trig),
   .trace_en     (trace_en),
   .trace_sample (trace_sample)
);

// File: tb/test_dbg_trigger_unit.sv
module test_dbg_trigger_unit;

   localparam int NT = 4;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_trig = '0;
   logic [1:0]    cfg_field = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          ibus_valid = 1'b0;
   logic [AW-1:0] ibus_addr = '0;
   logic          dbus_valid = 1'b0;
   logic          dbus_write = 1'b0;
   logic [AW-1:0] dbus_addr = '0;
   logic [DW-1:0] dbus_data = '0;
   logic [NT-1:0] trig_fired;
   logic          dbg_break, ext_trig, trace_en, trace_sample;

   always #4 clk = ~clk;

   dbg_trigger_unit #(.NUM_TRIG(NT), .ADDR_W(AW), .DATA_W(DW)) i_dbg_trigger_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_trig(cfg_trig),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .ibus_valid(ibus_valid),
      .ibus_addr(ibus_addr), .dbus_valid(dbus_valid), .dbus_write(dbus_write),
      .dbus_addr(dbus_addr), .dbus_data(dbus_data), .trig_fired(trig_fired),
      .dbg_break(dbg_break), .ext_trig(ext_trig), .trace_en(trace_en),
      .trace_sample(trace_sample)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   // Reference state
   logic [31:0]   m_addr [NT];
   logic [31:0]   m_data [NT];
   logic [31:0]   m_ctrl [NT];
   logic [NT-1:0] m_armed = '0;
   logic          m_trace = 1'b0;
   logic [NT-1:0] e_fired = '0;
   logic          e_brk = 1'b0, e_ext = 1'b0, e_smp = 1'b0;

   function automatic logic [31:0] mk(bit dbus, bit ua, bit ud, bit rd, bit wr, bit rng,
                                      bit narm, bit brk, bit ext, bit on, bit off,
                                      bit smp, logic [15:0] mask);
      return {mask, 3'b000, smp, off, on, ext, brk, narm, rng, wr, rd, ud, ua, dbus, 1'b1};
   endfunction

   function automatic bit inside_win(logic [31:0] v, logic [31:0] lo, logic [31:0] hi);
      return (v >= lo) && (v <= hi);
   endfunction

   task automatic model_step();
      logic [NT-1:0] f;
      bit brk_any, ext_any, on_any, off_any, smp_any;
      logic [NT-1:0] arm;
      f = '0; arm = '0;
      brk_any = 0; ext_any = 0; on_any = 0; off_any = 0; smp_any = 0;
      if (!rst_n) begin
         for (int i = 0; i < NT; i++) begin
            m_addr[i] = '0; m_data[i] = '0; m_ctrl[i] = '0;
         end
         m_armed = '0; m_trace = 0; e_fired = '0; e_brk = 0; e_ext = 0; e_smp = 0;
         return;
      end
      for (int i = 0; i < NT; i++) begin
         logic [31:0] c;
         int up;
         bit h;
         c  = m_ctrl[i];
         up = ((i % 2 == 0) && c[6]) ? i + 1 : i;
         h  = c[0];
         if ((i % 2 == 1) && m_ctrl[i-1][6]) h = 0;
         if (!c[1]) begin
            h = h && ibus_valid && (!c[2] || inside_win(ibus_addr, m_addr[i], m_addr[up]));
         end else begin
            h = h && dbus_valid
                  && (!c[2] || inside_win(dbus_addr, m_addr[i], m_addr[up]))
                  && (!c[3] || inside_win(dbus_data, m_data[i], m_data[up]))
                  && (!(c[4] || c[5]) || (c[4] && !dbus_write) || (c[5] && dbus_write));
         end
         if (c[7] && !m_armed[i]) h = 0;
         f[i] = h;
         if (h) begin
            brk_any |= c[8]; ext_any |= c[9]; on_any |= c[10]; off_any |= c[11];
            smp_any |= c[12] && c[1];
            arm |= c[16 +: NT];
         end
      end
      e_fired = f;
      e_brk   = brk_any;
      e_ext   = ext_any && !brk_any;
      e_smp   = smp_any && !brk_any;
      if (!brk_any) begin
         if (off_any) m_trace = 0;
         else if (on_any) m_trace = 1;
         m_armed |= arm;
      end
      if (cfg_we) begin
         m_armed = '0;
         case (cfg_field)
            2'd0: m_addr[cfg_trig] = cfg_wdata;
            2'd1: m_data[cfg_trig] = cfg_wdata;
            2'd2: m_ctrl[cfg_trig] = cfg_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic compare();
      n_chk++;
      if (trig_fired !== e_fired || dbg_break !== e_brk || ext_trig !== e_ext ||
          trace_en !== m_trace || trace_sample !== e_smp) begin
         n_bad++;
         $display("FAIL %s: fired=%b brk=%b ext=%b tr=%b smp=%b expected fired=%b brk=%b ext=%b tr=%b smp=%b",
                  cur_req, trig_fired, dbg_break, ext_trig, trace_en, trace_sample,
                  e_fired, e_brk, e_ext, m_trace, e_smp);
      end
   endtask

   task automatic pin(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic bus_idle();
      ibus_valid = 0; dbus_valid = 0; cfg_we = 0;
      ibus_addr = $urandom; dbus_addr = $urandom; dbus_data = $urandom;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         bus_idle();
         cyc();
      end
   endtask

   task automatic cfg(int t, int f, logic [31:0] v);
      bus_idle();
      cfg_we = 1; cfg_trig = 2'(t); cfg_field = 2'(f); cfg_wdata = v;
      cyc();
      cfg_we = 0;
   endtask

   task automatic ifetch(logic [31:0] a);
      bus_idle();
      ibus_valid = 1; ibus_addr = a;
      cyc();
   endtask

   task automatic dacc(bit w, logic [31:0] a, logic [31:0] d);
      bus_idle();
      dbus_valid = 1; dbus_write = w; dbus_addr = a; dbus_data = d;
      cyc();
   endtask

   task automatic clear_all();
      for (int t = 0; t < NT; t++) cfg(t, 2, 32'h0);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      @(negedge clk);
      for (int k = 0; k < 3; k++) cyc();
      rst_n = 1;
      idle(2);
      pin("R1", trace_en, 1'b0);
      pin("R1", |trig_fired, 1'b0);

      // R12: disabled slot stays quiet
      cur_req = "R12";
      cfg(0, 0, 32'h100);
      cfg(0, 2, mk(0,1,0,0,0,0,0,1,1,0,0,0,16'h0) & ~32'h1);
      ifetch(32'h100);
      pin("R12", dbg_break, 1'b0);
      idle(1);

      // R3: instruction breakpoint
      cur_req = "R3";
      cfg(0, 2, mk(0,1,0,0,0,0,0,1,0,0,0,0,16'h0));
      ifetch(32'h0FC);
      ifetch(32'h100);
      pin("R3", dbg_break, 1'b1);
      pin("R3", trig_fired[0], 1'b1);
      ifetch(32'h104);
      idle(1);

      // R2: field select 3 leaves registers alone
      cur_req = "R2";
      cfg(0, 3, 32'hFFFF_FFFF);
      ifetch(32'h100);
      pin("R2", dbg_break, 1'b1);
      cfg(0, 2, 32'h0);

      // R4: data-bus conditions ANDed
      cur_req = "R4";
      cfg(1, 0, 32'h200);
      cfg(1, 2, mk(1,1,0,0,1,0,0,0,1,0,0,0,16'h0));
      dacc(0, 32'h200, 32'h1);
      pin("R4", ext_trig, 1'b0);
      dacc(1, 32'h204, 32'h1);
      dacc(1, 32'h200, 32'h1);
      pin("R4", ext_trig, 1'b1);
      // R9: one pulse per firing cycle
      cur_req = "R9";
      dacc(1, 32'h200, 32'h2);
      pin("R9", ext_trig, 1'b1);
      idle(1);
      pin("R9", ext_trig, 1'b0);
      cur_req = "R4";
      cfg(2, 1, 32'hAB);
      cfg(2, 2, mk(1,0,1,1,0,0,0,0,0,0,0,1,16'h0));
      dacc(0, 32'h300, 32'hAB);
      pin("R4", trace_sample, 1'b1);
      dacc(1, 32'h300, 32'hAB);
      dacc(0, 32'h300, 32'hAC);
      pin("R4", trace_sample, 1'b0);
      clear_all();

      // R10: sticky trace, off wins
      cur_req = "R10";
      cfg(2, 0, 32'h400);
      cfg(2, 2, mk(1,1,0,0,0,0,0,0,0,1,0,0,16'h0));
      cfg(3, 0, 32'h404);
      cfg(3, 2, mk(1,1,0,0,0,0,0,0,0,0,1,0,16'h0));
      dacc(0, 32'h400, 32'h0);
      idle(2);
      pin("R10", trace_en, 1'b1);
      dacc(0, 32'h404, 32'h0);
      pin("R10", trace_en, 1'b0);
      dacc(0, 32'h400, 32'h0);
      cfg(3, 0, 32'h400);
      dacc(1, 32'h400, 32'h0);
      pin("R10", trace_en, 1'b0);
      clear_all();

      // R11: sample bit inert on instruction slot
      cur_req = "R11";
      cfg(0, 0, 32'h500);
      cfg(0, 2, mk(0,1,0,0,0,0,0,0,1,0,0,1,16'h0));
      ifetch(32'h500);
      pin("R11", ext_trig, 1'b1);
      pin("R11", trace_sample, 1'b0);
      clear_all();

      // R5: inclusive windows on pairs
      cur_req = "R5";
      cfg(0, 0, 32'h1000);
      cfg(1, 0, 32'h10FF);
      cfg(0, 2, mk(1,1,0,0,0,1,0,0,1,0,0,0,16'h0));
      cfg(1, 2, mk(1,1,0,0,0,0,0,1,0,0,0,0,16'h0));
      dacc(0, 32'h0FFF, 32'h0);
      dacc(0, 32'h1000, 32'h0);
      dacc(1, 32'h1080, 32'h0);
      dacc(0, 32'h10FF, 32'h0);
      pin("R5", ext_trig, 1'b1);
      pin("R5", dbg_break, 1'b0);
      dacc(0, 32'h1100, 32'h0);
      pin("R5", ext_trig, 1'b0);
      cfg(2, 1, 32'h10);
      cfg(3, 1, 32'h20);
      cfg(2, 2, mk(1,0,1,0,0,1,0,0,0,0,0,1,16'h0));
      dacc(1, 32'h0, 32'h0F);
      dacc(1, 32'h0, 32'h10);
      dacc(1, 32'h0, 32'h20);
      pin("R5", trace_sample, 1'b1);
      dacc(1, 32'h0, 32'h21);
      clear_all();

      // R6 / R7: armed slot
      cur_req = "R6";
      cfg(3, 0, 32'h700);
      cfg(3, 2, mk(1,1,0,0,0,0,1,0,1,0,0,0,16'h0));
      cfg(2, 0, 32'h600);
      cfg(2, 2, mk(1,1,0,0,0,0,0,0,0,0,0,0,16'h0008));
      dacc(0, 32'h700, 32'h0);
      pin("R6", ext_trig, 1'b0);
      dacc(0, 32'h600, 32'h0);
      dacc(0, 32'h700, 32'h0);
      pin("R6", ext_trig, 1'b1);
      idle(2);
      dacc(1, 32'h700, 32'h0);
      pin("R6", ext_trig, 1'b1);
      cur_req = "R7";
      cfg(0, 2, 32'h0);
      dacc(0, 32'h700, 32'h0);
      pin("R7", ext_trig, 1'b0);
      clear_all();

      // R8: break suppresses other actions
      cur_req = "R8";
      cfg(0, 0, 32'h800);
      cfg(1, 0, 32'h800);
      cfg(0, 2, mk(0,1,0,0,0,0,0,1,0,0,0,0,16'h0));
      cfg(1, 2, mk(0,1,0,0,0,0,0,0,1,1,0,0,16'h0));
      ifetch(32'h800);
      pin("R8", dbg_break, 1'b1);
      pin("R8", ext_trig, 1'b0);
      pin("R8", trace_en, 1'b0);
      cfg(0, 2, 32'h0);
      ifetch(32'h800);
      pin("R8", ext_trig, 1'b1);
      idle(3);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule